// File: doc/BRIEF.md
# Programmable Baud-Rate Tick Generator

This block divides the system clock by a 16-bit divisor and emits a one-cycle enable, `tick16x`, at sixteen times the wanted serial bit rate. The transmitter and receiver of a serial port use this enable to pace their oversampling and shifting. Software works out the divisor from the clock frequency and the baud rate. It then writes the divisor as two bytes, low and high, through a small write-only port. Each byte has its own latch.

A 16-bit down-counter runs from the divisor down to 1. When it reaches 1 the block raises the enable for one cycle and reloads the counter from the latches. Every divisor write also reloads the counter at once, with the freshly combined 16-bit value. A new rate therefore takes effect without finishing a long count left over from the previous one. A divisor of zero holds the generator stopped.

Top module: `baud_rate_gen`

## Requirements
- R1: After reset both divisor bytes and the counter are zero and `tick16x` stays low until a nonzero divisor is written.
- R2: A write with `wrSel`=0 stores `wrData` into bits 7:0 of the divisor. A write with `wrSel`=1 stores it into bits 15:8.
- R3: With a nonzero divisor D and no writes, `tick16x` is high for exactly one cycle in every D cycles.
- R4: A write to either byte reloads the counter with the new 16-bit divisor D. The first tick after a write appears D cycles after the clock edge that takes the write, and any count in progress is discarded.
- R5: `tick16x` is low in the cycle that follows a clock edge taking a write, even when a tick would otherwise be due.
- R6: A divisor of 1 makes `tick16x` high on every cycle that is not affected by a write.
- R7: A divisor of 0 produces no ticks at all.
- R8: The largest divisor, 65535, gives a tick period of 65535 cycles.
- R9: Writing one divisor byte leaves the other byte unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, used as the divider reference |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for a divisor byte |
| wrSel | input | 1 | Byte select: 0 selects the low byte, 1 selects the high byte |
| wrData | input | 8 | Byte value to store |
| tick16x | output | 1 | One-cycle enable at 16 times the baud rate |

## Verification
`tick16x` is registered. After a write taken at edge w, the first tick can be seen between edges w+D and w+D+1, and later ticks follow every D cycles. The cycle right after edge w is always quiet. The driver works out these cycle numbers from the divisor it has just written and queues them. It removes from the queue any tick that a new write cancels. The monitor samples on the falling edge and compares every cycle against the head of the queue, so a tick that comes early, late or not at all is reported in the exact cycle where it differs.

// File: rtl/baud_rate_gen_pkg.sv
package baud_rate_gen_pkg;

  // Strobes from control to datapath, valid for one cycle.
  typedef struct packed {
    logic loadCnt;    // write this cycle: counter takes the new divisor
    logic reloadCnt;  // terminal count: counter takes the latched divisor
    logic decCnt;     // running: counter steps down by one
    logic tickNext;   // tick register sets on this edge
  } ctlStrobes_t;

endpackage

// File: rtl/baud_rate_gen_ctrl.sv
module baud_rate_gen_ctrl
  import baud_rate_gen_pkg::*;
#(
  parameter int NUM_LAT = 2,
  parameter int SEL_W   = 1
) (
  input  logic               wrEn,
  input  logic [SEL_W-1:0]   wrSel,
  input  logic               divIsZero,
  input  logic               cntAtOne,
  output logic [NUM_LAT-1:0] latchWr,
  output ctlStrobes_t        stb
);

  // One-hot write enable, one bit per divisor byte latch.
  for (genvar i = 0; i < NUM_LAT; i++) begin : g_sel
    assign latchWr[i] = wrEn && (wrSel == SEL_W'(i));
  end

  // A write always wins. Otherwise a stopped generator holds.
  // A running one either reloads at the terminal count or steps down.
  always_comb begin
    stb           = '0;
    stb.loadCnt   = wrEn;
    stb.reloadCnt = !wrEn && !divIsZero && cntAtOne;
    stb.decCnt    = !wrEn && !divIsZero && !cntAtOne;
    stb.tickNext  = !wrEn && !divIsZero && cntAtOne;
  end

endmodule

// File: rtl/baud_rate_gen_dp.sv
module baud_rate_gen_dp
  import baud_rate_gen_pkg::*;
#(
  parameter int DIV_W   = 16,
  parameter int BYTE_W  = 8,
  parameter int NUM_LAT = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [BYTE_W-1:0]  wrData,
  input  logic [NUM_LAT-1:0] latchWr,
  input  ctlStrobes_t        stb,
  output logic [DIV_W-1:0]   divisor,
  output logic [DIV_W-1:0]   count,
  output logic               divIsZero,
  output logic               cntAtOne,
  output logic               tick
);

  logic [DIV_W-1:0] divNext;

  // Byte latches. The next value merges the byte being written this cycle,
  // so the counter can load the complete new divisor on the same edge.
  for (genvar i = 0; i < NUM_LAT; i++) begin : g_lat
    logic [BYTE_W-1:0] latQ;
    always_ff @(posedge clk) begin
      if (!rstN)          latQ <= '0;
      else if (latchWr[i]) latQ <= wrData;
    end
    assign divisor[i*BYTE_W +: BYTE_W] = latQ;
    assign divNext[i*BYTE_W +: BYTE_W] = latchWr[i] ? wrData : latQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
      tick  <= 1'b0;
    end else begin
      if (stb.loadCnt)        count <= divNext;
      else if (stb.reloadCnt) count <= divisor;
      else if (stb.decCnt)    count <= count - DIV_W'(1);
      tick <= stb.tickNext;
    end
  end

  assign divIsZero = (divisor == '0);
  assign cntAtOne  = (count == DIV_W'(1));

endmodule

// File: rtl/baud_rate_gen.sv
module baud_rate_gen
  import baud_rate_gen_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [BYTE_W-1:0] wrData,
  output logic              tick16x
);

  localparam int NUM_LAT = DIV_W / BYTE_W;
  localparam int SEL_W   = (NUM_LAT > 1) ? $clog2(NUM_LAT) : 1;

  logic [NUM_LAT-1:0] latchWr;
  ctlStrobes_t        stb;
  logic [DIV_W-1:0]   divisorVal;
  logic [DIV_W-1:0]   countVal;
  logic               divIsZero;
  logic               cntAtOne;

  baud_rate_gen_ctrl #(.NUM_LAT(NUM_LAT), .SEL_W(SEL_W)) u_ctrl (
    .wrEn      (wrEn),
    .wrSel     (SEL_W'(wrSel)),
    .divIsZero (divIsZero),
    .cntAtOne  (cntAtOne),
    .latchWr   (latchWr),
    .stb       (stb)
  );

  baud_rate_gen_dp #(.DIV_W(DIV_W), .BYTE_W(BYTE_W), .NUM_LAT(NUM_LAT)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .wrData    (wrData),
    .latchWr   (latchWr),
    .stb       (stb),
    .divisor   (divisorVal),
    .count     (countVal),
    .divIsZero (divIsZero),
    .cntAtOne  (cntAtOne),
    .tick      (tick16x)
  );

endmodule

// File: rtl/baud_rate_gen_chk.sv
module baud_rate_gen_chk #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic             tick16x,
  input logic [DIV_W-1:0] divisor,
  input logic [DIV_W-1:0] count
);

  AST_WRITE_SILENCES: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !tick16x);                                        // R5

  AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (divisor == '0) |=> !tick16x);                             // R7

  AST_DIV_ONE_EVERY: assert property (@(posedge clk) disable iff (!rstN)
    (divisor == DIV_W'(1) && !wrEn) |=> tick16x);              // R6

  AST_WRITE_RELOADS: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (count == divisor));                              // R4

  AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (divisor != '0) |-> (count >= DIV_W'(1) && count <= divisor)); // R3

  AST_TICK_FROM_ONE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tick16x) |-> ($past(count) == DIV_W'(1)));           // R3

endmodule

bind baud_rate_gen baud_rate_gen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .tick16x (tick16x),
  .divisor (divisorVal),
  .count   (countVal)
);

// File: tb/baud_rate_gen_tb.sv
module baud_rate_gen_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic       wrSel = 1'b0;
  logic [7:0] wrData = '0;
  logic       tick16x;

  int  checks = 0;
  int  failures = 0;
  int  cyc = 0;
  int  modelCyc = 0;
  int  nextTick = 0;
  int  curDiv = 0;
  logic [7:0] latLo = '0;
  logic [7:0] latHi = '0;
  bit  monOn = 1'b0;
  bit  done = 1'b0;
  bit  expTick;
  string curReq = "R1";
  int  expQ[$];

  always #10 clk = ~clk;   // 50 MHz

  baud_rate_gen u_dut (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrSel   (wrSel),
    .wrData  (wrData),
    .tick16x (tick16x)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare every cycle with the head of the expected-tick queue.
  always @(negedge clk) begin
    if (monOn && !done) begin
      expTick = (expQ.size() > 0 && expQ[0] == cyc);
      if (expTick) void'(expQ.pop_front());
      checks++;
      if (tick16x !== expTick) begin
        failures++;
        $display("FAIL %s cyc=%0d tick16x actual=%0b expected=%0b",
                 curReq, cyc, tick16x, expTick);
      end
    end
  end

  // Predict the ticks for the next n cycles, then let them run.
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      modelCyc++;
      if (curDiv != 0 && modelCyc == nextTick) begin
        expQ.push_back(modelCyc);
        nextTick += curDiv;
      end
    end
    repeat (n) @(negedge clk);
  endtask

  // Write one divisor byte; the edge that takes it is cyc+1.
  task automatic writeByte(input bit sel, input logic [7:0] val);
    int w;
    w = modelCyc + 1;
    while (expQ.size() > 0 && expQ[$] >= w) void'(expQ.pop_back());
    wrEn = 1'b1; wrSel = sel; wrData = val;
    if (sel) latHi = val; else latLo = val;   // R2, R9: other byte untouched
    curDiv   = {latHi, latLo};
    nextTick = w + curDiv;                     // R4
    modelCyc = w;                              // R5: cycle w carries no tick
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (tick16x !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset tick16x actual=%0b expected=0", tick16x);
    end
    rstN = 1'b1;
    modelCyc = cyc;
    monOn = 1'b1;

    curReq = "R1"; idle(50);                            // unprogrammed: quiet
    curReq = "R3"; writeByte(1'b0, 8'd4); idle(40);     // D=4
    curReq = "R6"; writeByte(1'b0, 8'd1); idle(20);     // D=1
    curReq = "R7"; writeByte(1'b0, 8'd0); idle(30);     // D=0 stopped
    curReq = "R4"; writeByte(1'b0, 8'd7); idle(4);      // mid count
    writeByte(1'b0, 8'd3); idle(30);                    // reload to 3
    curReq = "R9"; writeByte(1'b1, 8'd1); idle(600);    // D=0x0103
    curReq = "R2"; writeByte(1'b1, 8'd0); idle(8);      // D=3
    curReq = "R5"; writeByte(1'b0, 8'd1); idle(10);     // D=1
    writeByte(1'b0, 8'd1); idle(5);                     // suppressed cycle
    writeByte(1'b0, 8'd1); writeByte(1'b0, 8'd1); idle(5);
    curReq = "R8"; writeByte(1'b0, 8'hFF); writeByte(1'b1, 8'hFF);
    idle(65540);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired at cyc=%0d actual=running expected=finished", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule